// File: doc/BRIEF.md
# Redundant Residue Word Checker and Binary Converter

This block receives one operand held as six residues: four main residues (moduli 199, 233, 194 and 239) that together fix any value below their product, and two check residues (moduli 251 and 509) that carry no extra information about the value. The block decides whether the six residues agree. If they do not, it locates and repairs a single wrong residue where that is possible. It then delivers the value as a 32-bit binary number. It sits between residue arithmetic and anything that needs ordinary binary, such as address generation or output to the outside.

The block works serially. First it rebuilds the value from the four main residues by mixed-radix steps, one modular multiply-accumulate per clock. It then compares the two check residues against that value. If both agree, the result is ready six clocks after acceptance. If either disagrees, the block runs six more trials. Each trial sets one slice aside, rebuilds the value from four of the other five, and compares it with the fifth. A trial passes only if the rebuilt value is below the product of the main moduli. One passing trial gives a corrected result. Any other outcome is reported as uncorrectable. A mismatched word always takes 42 clocks, whatever it contains.

Top module: `rrns_decoder`

## Requirements
- R1: After reset, inReady is 1, resValid is 0, resOk, resCorrected and resUncorrectable are 0, resValue is 0 and resSlice is 7.
- R2: A word is taken at a rising edge where inValid and inReady are both 1. inReady is 0 from the next cycle until the cycle that presents its result. Words offered while inReady is 0 have no effect on any result.
- R3: When all six residues equal the residues of one value below M = 2149852322 (the product of the four main moduli), the result has resOk=1 and resValue equal to that value. resValid rises after the sixth rising edge that follows the accepting edge.
- R4: The all-zero word gives resOk=1 and resValue=0.
- R5: When exactly one residue (within its modulus range) differs from the residues of a value below M, the result has resCorrected=1, resValue equal to that value, and resSlice equal to the index (0 to 5) of the wrong field.
- R6: A field that holds a number at or above its own modulus is treated as a wrong residue. A single such field is repaired as in R5.
- R7: A word with two wrong residues is never reported as resOk. A word where no trial passes, or more than one trial passes, gives resUncorrectable=1, resValue=0 and resSlice=7. Each result raises exactly one of the three flags.
- R8: A result that is not resOk appears after the 42nd rising edge that follows the accepting edge. resValid is high for exactly one cycle, and the result outputs hold until the next result.
- R9: Field layout in inWord: slice 0 (mod 199) is bits 7:0, slice 1 (mod 233) is bits 15:8, slice 2 (mod 194) is bits 23:16, slice 3 (mod 239) is bits 31:24, slice 4 (mod 251) is bits 39:32, and slice 5 (mod 509) is bits 48:40. Trial k (k = 1 to 6) sets slice k-1 aside, and resSlice reports that slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A word is offered |
| inReady | output | 1 | The block can take a word this cycle |
| inWord | input | 49 | Six packed residues |
| resValid | output | 1 | One-cycle strobe: result outputs are new |
| resValue | output | 32 | Binary value (0 when uncorrectable) |
| resOk | output | 1 | Residues were consistent |
| resCorrected | output | 1 | One residue was repaired |
| resUncorrectable | output | 1 | Word could not be decoded |
| resSlice | output | 3 | Index of the repaired slice, 7 if none |

## Verification
Two events can share a cycle: the one-cycle result strobe and the acceptance of the next word, because inReady returns high in the same cycle that resValid is raised. The bench provokes this by holding inValid high with a second word for the whole time the first word is being decoded. It judges two things. The first result must match the first word alone. The second word must then be accepted on the edge right after that result, with its own latency counted from that edge and its own decoded value.

// File: rtl/rrns_pkg.sv
package rrns_pkg;

  localparam int NumSlices     = 6;
  localparam int NumMain       = 4;
  localparam int NumTrials     = NumSlices + 1;
  localparam int StepsPerTrial = NumSlices;
  localparam int NarrowW       = 8;
  localparam int WideW         = 9;
  localparam int WordW         = (NumSlices - 1) * NarrowW + WideW;
  localparam int ValW          = 32;
  localparam int AccW          = 34;
  localparam int ResW          = WideW;
  localparam int IdxW          = 3;
  localparam int TrialW        = 3;
  localparam int StepW         = 3;
  localparam int NoSliceIdx    = (1 << IdxW) - 1;
  localparam int OkLatency     = StepsPerTrial + 1;
  localparam int FullLatency   = NumTrials * StepsPerTrial + 1;

  function automatic int modOf(input int k);
    case (k)
      0: return 199;
      1: return 233;
      2: return 194;
      3: return 239;
      4: return 251;
      5: return 509;
      default: return 1;
    endcase
  endfunction

  function automatic int fieldLsb(input int k);
    return k * NarrowW;
  endfunction

  function automatic int fieldW(input int k);
    return (k == NumSlices - 1) ? WideW : NarrowW;
  endfunction

  function automatic longint mainProduct();
    longint p;
    p = 1;
    for (int k = 0; k < NumMain; k++) p = p * modOf(k);
    return p;
  endfunction

  // Slice handled at a given step of a trial; trial 0 sets nothing aside,
  // trial t sets slice t-1 aside and visits it last (its comparison is masked).
  function automatic int sliceAt(input int trial, input int step);
    int e;
    if (trial == 0) return step;
    e = trial - 1;
    if (step == NumSlices - 1) return e;
    if (step < e) return step;
    return step + 1;
  endfunction

  function automatic int modInv(input int a, input int m);
    int r;
    r = 0;
    for (int i = 1; i < m; i++) if (r == 0 && ((a * i) % m) == 1) r = i;
    return r;
  endfunction

  // Inverse of the partial radix product modulo the next basis modulus.
  function automatic int stepInv(input int trial, input int step);
    longint p;
    int m;
    if (trial >= NumTrials || step < 1 || step >= NumMain) return 0;
    p = 1;
    for (int j = 0; j < step; j++) p = p * modOf(sliceAt(trial, j));
    m = modOf(sliceAt(trial, step));
    return modInv(int'(p % m), m);
  endfunction

  typedef struct packed {
    logic                 clear;
    logic                 load;
    logic                 acc;
    logic                 cmp;
    logic                 endTrial;
    logic [IdxW-1:0]      slice;
    logic [TrialW-1:0]    trial;
    logic [StepW-1:0]     step;
    logic [NumSlices-1:0] exclOh;
  } ctlStrobe_t;

endpackage

// File: rtl/rrns_control.sv
module rrns_control
  import rrns_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       trialPass,
  output logic       inReady,
  output ctlStrobe_t ctl
);

  typedef enum logic {StIdle, StRun} state_t;

  state_t            stateQ;
  logic [TrialW-1:0] trialQ;
  logic [StepW-1:0]  stepQ;
  logic              running;
  logic              lastStep;
  logic              accept;
  logic              stopNow;

  assign running  = (stateQ == StRun);
  assign inReady  = (stateQ == StIdle);
  assign accept   = inValid && inReady;
  assign lastStep = (stepQ == StepW'(StepsPerTrial - 1));
  assign stopNow  = ((trialQ == '0) && trialPass) ||
                    (trialQ == TrialW'(NumTrials - 1));

  always_comb begin
    ctl       = '0;
    ctl.clear = accept;
    ctl.trial = trialQ;
    ctl.step  = stepQ;
    if (running) begin
      ctl.slice    = IdxW'(sliceAt(int'(trialQ), int'(stepQ)));
      ctl.exclOh   = (trialQ == '0) ? '0 :
                     (NumSlices'(1) << (trialQ - TrialW'(1)));
      ctl.load     = (stepQ == '0);
      ctl.acc      = (stepQ != '0) && (stepQ < StepW'(NumMain));
      ctl.cmp      = (stepQ >= StepW'(NumMain));
      ctl.endTrial = lastStep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= StIdle;
      trialQ <= '0;
      stepQ  <= '0;
    end else begin
      case (stateQ)
        StIdle: begin
          if (accept) begin
            stateQ <= StRun;
            trialQ <= '0;
            stepQ  <= '0;
          end
        end
        default: begin
          if (lastStep) begin
            stepQ <= '0;
            if (stopNow) stateQ <= StIdle;
            else         trialQ <= trialQ + TrialW'(1);
          end else begin
            stepQ <= stepQ + StepW'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rrns_datapath.sv
module rrns_datapath
  import rrns_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      ctl,
  input  logic [WordW-1:0] inWord,
  output logic            trialPass,
  output logic            resValid,
  output logic [ValW-1:0] resValue,
  output logic            resOk,
  output logic            resCorrected,
  output logic            resUncorrectable,
  output logic [IdxW-1:0] resSlice
);

  localparam int SelN = 1 << IdxW;
  localparam int InvN = 1 << (TrialW + StepW);
  localparam logic [AccW-1:0] RangeM = AccW'(mainProduct());

  logic [WordW-1:0]     wordQ;
  logic [ResW-1:0]      resid [SelN];
  logic [ResW-1:0]      modK  [SelN];
  logic [NumSlices-1:0] inRange;
  logic [ResW-1:0]      invTab [InvN];

  for (genvar k = 0; k < SelN; k++) begin : gSlice
    if (k < NumSlices) begin : gReal
      localparam int Lsb = fieldLsb(k);
      localparam int Wid = fieldW(k);
      assign resid[k]   = ResW'(wordQ[Lsb +: Wid]);
      assign modK[k]    = ResW'(modOf(k));
      assign inRange[k] = (resid[k] < modK[k]);
    end else begin : gPad
      assign resid[k] = '0;
      assign modK[k]  = ResW'(1);
    end
  end

  for (genvar t = 0; t < (1 << TrialW); t++) begin : gInvT
    for (genvar s = 0; s < (1 << StepW); s++) begin : gInvS
      assign invTab[t * (1 << StepW) + s] = ResW'(stepInv(t, s));
    end
  end

  logic [AccW-1:0] accX, accP;
  logic            chkQ;
  logic [1:0]      passCntQ;
  logic [ValW-1:0] candQ;
  logic [IdxW-1:0] candIdxQ;

  logic [ResW-1:0] curRes, curMod, curInv;
  logic [AccW-1:0] modExt, remX, diffV, digit, nextX;
  logic            cmpHit, chkAfter, rangeAll;

  assign curRes = resid[ctl.slice];
  assign curMod = modK[ctl.slice];
  assign curInv = invTab[{ctl.trial, ctl.step}];
  assign modExt = AccW'(curMod);
  assign remX   = accX % modExt;
  assign diffV  = (AccW'(curRes) + modExt - remX) % modExt;
  assign digit  = (diffV * AccW'(curInv)) % modExt;
  assign nextX  = accX + accP * digit;

  assign rangeAll  = &(inRange | ctl.exclOh);
  assign cmpHit    = (remX == AccW'(curRes)) || ctl.exclOh[ctl.slice];
  assign chkAfter  = chkQ && cmpHit;
  assign trialPass = chkAfter && (accX < RangeM);

  logic            passHere, finishOk, finishScan;
  logic [1:0]      cntNext, cntFinal;
  logic [ValW-1:0] candFinal;
  logic [IdxW-1:0] idxFinal, idxHere;

  assign passHere   = ctl.endTrial && (ctl.trial != '0) && trialPass;
  assign finishOk   = ctl.endTrial && (ctl.trial == '0) && trialPass;
  assign finishScan = ctl.endTrial && (ctl.trial == TrialW'(NumTrials - 1));
  assign idxHere    = IdxW'(ctl.trial - TrialW'(1));
  assign cntNext    = (passCntQ == 2'd2) ? 2'd2 : passCntQ + 2'd1;
  assign cntFinal   = passHere ? cntNext : passCntQ;
  assign candFinal  = (passHere && passCntQ == 2'd0) ? accX[ValW-1:0] : candQ;
  assign idxFinal   = (passHere && passCntQ == 2'd0) ? idxHere : candIdxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ            <= '0;
      accX             <= '0;
      accP             <= '0;
      chkQ             <= 1'b0;
      passCntQ         <= '0;
      candQ            <= '0;
      candIdxQ         <= '0;
      resValid         <= 1'b0;
      resValue         <= '0;
      resOk            <= 1'b0;
      resCorrected     <= 1'b0;
      resUncorrectable <= 1'b0;
      resSlice         <= IdxW'(NoSliceIdx);
    end else begin
      resValid <= 1'b0;
      if (ctl.clear) begin
        wordQ    <= inWord;
        passCntQ <= '0;
        candQ    <= '0;
        candIdxQ <= '0;
      end
      if (ctl.load) begin
        accX <= AccW'(curRes);
        accP <= modExt;
        chkQ <= rangeAll;
      end
      if (ctl.acc) begin
        accX <= nextX;
        accP <= accP * modExt;
      end
      if (ctl.cmp) chkQ <= chkAfter;
      if (passHere) begin
        passCntQ <= cntNext;
        candQ    <= candFinal;
        candIdxQ <= idxFinal;
      end
      if (finishOk) begin
        resValid         <= 1'b1;
        resValue         <= accX[ValW-1:0];
        resOk            <= 1'b1;
        resCorrected     <= 1'b0;
        resUncorrectable <= 1'b0;
        resSlice         <= IdxW'(NoSliceIdx);
      end else if (finishScan) begin
        resValid <= 1'b1;
        resOk    <= 1'b0;
        if (cntFinal == 2'd1) begin
          resValue         <= candFinal;
          resCorrected     <= 1'b1;
          resUncorrectable <= 1'b0;
          resSlice         <= idxFinal;
        end else begin
          resValue         <= '0;
          resCorrected     <= 1'b0;
          resUncorrectable <= 1'b1;
          resSlice         <= IdxW'(NoSliceIdx);
        end
      end
    end
  end

endmodule

// File: rtl/rrns_decoder.sv
module rrns_decoder
  import rrns_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WordW-1:0] inWord,
  output logic             resValid,
  output logic [ValW-1:0]  resValue,
  output logic             resOk,
  output logic             resCorrected,
  output logic             resUncorrectable,
  output logic [IdxW-1:0]  resSlice
);

  ctlStrobe_t ctl;
  logic       trialPass;

  rrns_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .trialPass(trialPass),
    .inReady  (inReady),
    .ctl      (ctl)
  );

  rrns_datapath u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .ctl             (ctl),
    .inWord          (inWord),
    .trialPass       (trialPass),
    .resValid        (resValid),
    .resValue        (resValue),
    .resOk           (resOk),
    .resCorrected    (resCorrected),
    .resUncorrectable(resUncorrectable),
    .resSlice        (resSlice)
  );

endmodule

// File: rtl/rrns_decoder_chk.sv
module rrns_decoder_chk
  import rrns_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inReady,
  input logic            resValid,
  input logic [ValW-1:0] resValue,
  input logic            resOk,
  input logic            resCorrected,
  input logic            resUncorrectable,
  input logic [IdxW-1:0] resSlice
);

  localparam logic [ValW-1:0] RangeTop = ValW'(mainProduct());

  logic [6:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   latCnt <= '0;
    else if (inValid && inReady) latCnt <= 7'd1;
    else if (resValid)           latCnt <= '0;
    else if (latCnt != '0)       latCnt <= latCnt + 7'd1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  a_r8_latency_fixed: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (latCnt == 7'(OkLatency) || latCnt == 7'(FullLatency)));

  a_r8_latency_bound: assert property (@(posedge clk) disable iff (!rstN)
    latCnt <= 7'(FullLatency));

  a_r3_ok_early: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resOk) |-> latCnt == 7'(OkLatency));

  a_r3_value_range: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resValue < RangeTop);

  a_r7_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $countones({resOk, resCorrected, resUncorrectable}) == 1);

  a_r7_zero_on_fail: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resUncorrectable) |-> (resValue == '0 && resSlice == IdxW'(NoSliceIdx)));

  a_r5_slice_index: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCorrected) |-> resSlice < IdxW'(NumSlices));

endmodule

bind rrns_decoder rrns_decoder_chk u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .inValid         (inValid),
  .inReady         (inReady),
  .resValid        (resValid),
  .resValue        (resValue),
  .resOk           (resOk),
  .resCorrected    (resCorrected),
  .resUncorrectable(resUncorrectable),
  .resSlice        (resSlice)
);

// File: tb/rrns_decoder_bench.sv
module rrns_decoder_bench;

  localparam int ClkPeriod = 10;
  localparam longint RangeM = 64'd2149852322;
  localparam int NumVec = 12;

  // {value[31:0], sliceA[2:0], deltaA[8:0], sliceB[2:0], deltaB[8:0]}; slice 7 = untouched
  localparam logic [55:0] Vecs [NumVec] = '{
    {32'd12345,      3'd7, 9'd0,   3'd7, 9'd0},
    {32'd2149852321, 3'd7, 9'd0,   3'd7, 9'd0},
    {32'd1000000,    3'd0, 9'd1,   3'd7, 9'd0},
    {32'd77777777,   3'd1, 9'd5,   3'd7, 9'd0},
    {32'd305419896,  3'd2, 9'd100, 3'd7, 9'd0},
    {32'd987654321,  3'd3, 9'd1,   3'd7, 9'd0},
    {32'd42,         3'd4, 9'd7,   3'd7, 9'd0},
    {32'd2000000000, 3'd5, 9'd300, 3'd7, 9'd0},
    {32'd5555,       3'd0, 9'd1,   3'd1, 9'd1},
    {32'd123456789,  3'd4, 9'd1,   3'd5, 9'd1},
    {32'd1,          3'd2, 9'd3,   3'd5, 9'd9},
    {32'd0,          3'd3, 9'd200, 3'd7, 9'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [48:0] inWord = '0;
  logic        inReady, resValid, resOk, resCorrected, resUncorrectable;
  logic [31:0] resValue;
  logic [2:0]  resSlice;

  int checks = 0;
  int errors = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  rrns_decoder u_rrns_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .resValid(resValid), .resValue(resValue), .resOk(resOk),
    .resCorrected(resCorrected), .resUncorrectable(resUncorrectable), .resSlice(resSlice)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int benchMod(input int k);
    case (k)
      0: return 199; 1: return 233; 2: return 194;
      3: return 239; 4: return 251; default: return 509;
    endcase
  endfunction

  function automatic int getField(input logic [48:0] w, input int k);
    if (k == 5) return int'(w[48:40]);
    return int'(w[k*8 +: 8]);
  endfunction

  function automatic logic [48:0] setField(input logic [48:0] w, input int k, input int v);
    logic [48:0] r;
    r = w;
    if (k == 5) r[48:40] = 9'(v);
    else        r[k*8 +: 8] = 8'(v);
    return r;
  endfunction

  function automatic logic [48:0] encode(input longint v);
    logic [48:0] w;
    w = '0;
    for (int k = 0; k < 6; k++) w = setField(w, k, int'(v % benchMod(k)));
    return w;
  endfunction

  // Independent model: plain CRT over every slice not set aside.
  task automatic refTrial(input logic [48:0] w, input int excl,
                          output bit pass, output longint x);
    longint p, acc, mi, inv, term;
    int m, r;
    bit rangeOk;
    p = 1; rangeOk = 1; acc = 0;
    for (int k = 0; k < 6; k++) if (k != excl) begin
      m = benchMod(k); r = getField(w, k);
      if (r >= m) rangeOk = 0;
      p = p * m;
    end
    for (int k = 0; k < 6; k++) if (k != excl) begin
      m = benchMod(k); r = getField(w, k) % m;
      mi = p / m; inv = 0;
      for (int i = 1; i < m; i++) if (inv == 0 && (((mi % m) * i) % m) == 1) inv = i;
      term = (((mi * inv) % p) * r) % p;
      acc = (acc + term) % p;
    end
    x = acc;
    pass = rangeOk && (acc < RangeM);
  endtask

  task automatic refDecode(input logic [48:0] w, output bit eOk, output bit eCorr,
                           output bit eUnc, output int eSlice, output longint eVal);
    bit pass;
    longint x, firstX;
    int cnt, firstE;
    refTrial(w, -1, pass, x);
    eOk = pass; eCorr = 0; eUnc = 0; eSlice = 7; eVal = pass ? x : 0;
    if (!pass) begin
      cnt = 0; firstE = 7; firstX = 0;
      for (int e = 0; e < 6; e++) begin
        refTrial(w, e, pass, x);
        if (pass) begin
          if (cnt == 0) begin firstE = e; firstX = x; end
          cnt++;
        end
      end
      if (cnt == 1) begin eCorr = 1; eSlice = firstE; eVal = firstX; end
      else eUnc = 1;
    end
  endtask

  task automatic waitResult(output int lat);
    lat = 1;
    while (!resValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic judge(input string req, input logic [48:0] w, input int lat);
    bit eOk, eCorr, eUnc;
    int eSlice;
    longint eVal;
    refDecode(w, eOk, eCorr, eUnc, eSlice, eVal);
    check(resValid == 1'b1, req, "result strobe", longint'(resValid), 1);
    check(resOk == eOk, req, "ok flag", longint'(resOk), longint'(eOk));
    check(resCorrected == eCorr, req, "corrected flag", longint'(resCorrected), longint'(eCorr));
    check(resUncorrectable == eUnc, req, "uncorrectable flag", longint'(resUncorrectable), longint'(eUnc));
    check(int'(resSlice) == eSlice, req, "slice", longint'(resSlice), longint'(eSlice));
    check(longint'(resValue) == eVal, req, "value", longint'(resValue), eVal);
    // R3 / R8: ok results after 6 edges, others after 42 (counted here in falling edges)
    check(lat == (eOk ? 7 : 43), eOk ? "R3" : "R8", "latency", longint'(lat), eOk ? 7 : 43);
  endtask

  task automatic runWord(input string req, input logic [48:0] w);
    int lat;
    @(negedge clk);
    check(inReady == 1'b1, "R2", "ready before offer", longint'(inReady), 1);
    inValid = 1'b1; inWord = w;
    @(negedge clk);
    inValid = 1'b0;
    waitResult(lat);
    judge(req, w, lat);
    @(negedge clk);
    check(resValid == 1'b0, "R8", "strobe lasts one cycle", longint'(resValid), 0);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [48:0] w, w2;
    int lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(inReady == 1'b1, "R1", "ready", longint'(inReady), 1);
    check(resValid == 1'b0, "R1", "strobe", longint'(resValid), 0);
    check({resOk, resCorrected, resUncorrectable} == 3'b000, "R1", "flags",
          longint'({resOk, resCorrected, resUncorrectable}), 0);
    check(resValue == 32'd0, "R1", "value", longint'(resValue), 0);
    check(resSlice == 3'd7, "R1", "slice", longint'(resSlice), 7);

    for (int i = 0; i < NumVec; i++) begin
      logic [55:0] v;
      int sa, sb;
      bit ok2;
      v = Vecs[i];
      w = encode(longint'(v[55:24]));
      sa = int'(v[23:21]); sb = int'(v[11:9]);
      if (sa != 7) w = setField(w, sa, (getField(w, sa) + int'(v[20:12])) % benchMod(sa));
      if (sb != 7) w = setField(w, sb, (getField(w, sb) + int'(v[8:0])) % benchMod(sb));
      if (sb != 7) begin
        runWord("R7", w);
        ok2 = resOk;
        check(ok2 == 1'b0, "R7", "double error not ok", longint'(ok2), 0);
      end else if (sa != 7) begin
        runWord("R5", w);
      end else begin
        runWord("R3", w);
      end
    end

    // R4 all-zero word
    runWord("R4", '0);
    check(resOk == 1'b1 && resValue == 32'd0, "R4", "zero word", longint'(resValue), 0);

    // R9 hand-packed fields for value 200
    runWord("R9", {9'd200, 8'd200, 8'd200, 8'd6, 8'd200, 8'd1});
    check(resValue == 32'd200, "R9", "hand-packed value", longint'(resValue), 200);

    // R6 out-of-range field in slice 1
    w = setField(encode(64'd31337), 1, 255);
    runWord("R6", w);
    check(resCorrected == 1'b1 && resSlice == 3'd1, "R6", "slice of bad field",
          longint'(resSlice), 1);

    // R7 value above the legitimate range
    runWord("R7", encode(RangeM + 5));

    // R2: second word held during busy; taken in the result cycle
    w  = encode(64'd424242);
    w2 = setField(encode(64'd99999), 4, 3);
    @(negedge clk);
    inValid = 1'b1; inWord = w;
    @(negedge clk);
    inWord = w2;
    check(inReady == 1'b0, "R2", "ready low while busy", longint'(inReady), 0);
    waitResult(lat);
    judge("R2", w, lat);
    check(inReady == 1'b1, "R2", "ready with result", longint'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R2", "second word taken", longint'(inReady), 0);
    waitResult(lat);
    judge("R2", w2, lat);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule